// File: doc/BRIEF.md
# Sequence-Number Stream Aligner

This block sits behind two receive front ends that share a sample clock. It lines up their sample streams so that matching samples leave together. Each stream is a series of frames of complex words. The first word of every frame is a 32-bit sample number. The remaining one or three words carry data channels. The aligner gathers one whole frame from each side and compares the two sample numbers. If they differ, it throws away the frame that lags. If they agree, it replays both frames word by word on two output streams that advance together.

Matching is done only by discarding frames. There is no delay line and no timestamp buffer. Once the two streams have agreed at least once, any later disagreement raises a sticky flag. The block then goes back to discarding frames until the sample numbers agree again.

Each complex word is 32 bits wide: bits 31:16 hold I and bits 15:0 hold Q. The parameter `ALIGN_INTERVAL` exists for interface compatibility and has no effect on behaviour.

Top module: `seqnum_stream_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it is released, both output valids are low, both input readies are high and `align_lost` is low.
- R2: A frame is exactly `NUM_CHAN` words (`NUM_CHAN` is 2 or 4). Word 0 carries the sample number, formed as {I half, Q half} with I (bits 31:16) as the upper 16 bits.
- R3: When both held frames carry equal sample numbers, the block emits them in full on both outputs. Word 0 (the sample number) comes first and the data words follow in their input order.
- R4: When the held sample numbers differ, the block discards the whole frame with the smaller number and nothing of it is emitted. At most one frame is discarded per cycle.
- R5: "Smaller" means the 32-bit wrap-around difference is negative. So 0xFFFFFFFE and 0xFFFFFFFF count as behind 0x00000000.
- R6: Output valids are high only together, only while both output readies are high, and only during the emission of a matched frame.
- R7: A partial frame is never emitted. Output stays idle until both sides hold a complete frame.
- R8: `align_lost` rises when sample numbers differ after at least one frame has been emitted. Only reset clears it. Mismatches before the first emission leave it low, and after a loss the block realigns by discarding.
- R9: Each input's ready is low from the cycle after its frame completes until that frame is emitted or discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_in_valid | input | 1 | Master input word valid |
| m_in_ready | output | 1 | Master input can take a word |
| m_in_data | input | 32 | Master input word {I,Q} |
| s_in_valid | input | 1 | Slave input word valid |
| s_in_ready | output | 1 | Slave input can take a word |
| s_in_data | input | 32 | Slave input word {I,Q} |
| m_out_valid | output | 1 | Master aligned word valid |
| m_out_ready | input | 1 | Master aligned sink ready |
| m_out_data | output | 32 | Master aligned word |
| s_out_valid | output | 1 | Slave aligned word valid |
| s_out_ready | input | 1 | Slave aligned sink ready |
| s_out_data | output | 32 | Slave aligned word |
| align_lost | output | 1 | Sticky flag: alignment was held and then broken |

## Verification
An error in the per-stream word index shows on the very first emitted frame. The sample number would appear in a non-zero position, or the data words would come out rotated. A wrong discard decision shows within one frame time, because the first emitted sample number no longer equals the larger starting value. When the compare ignores wrap-around, no frame is emitted at all and one input's ready stays low. A broken emission counter, or a lockstep gate that is wrong, puts the two outputs' words out of step at once. A flag that is set wrongly, or never set, is visible on `align_lost` one cycle after the discard decision.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
   localparam int unsigned CWORD_W = 32;
   typedef logic [CWORD_W-1:0] cword_t;

   // Wrap-around ordering of two sequence numbers: a lags b.
   function automatic logic seq_lags(input cword_t a, input cword_t b);
      cword_t diff;
      diff = a - b;
      return diff[CWORD_W-1];
   endfunction
endpackage

// File: rtl/frame_collector.sv
module frame_collector #(
   parameter int unsigned NUM_CHAN = 2,
   parameter int unsigned WORD_W   = 32
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             in_valid,
   output logic                             in_ready,
   input  logic [WORD_W-1:0]                in_data,
   input  logic                             release_i,
   output logic                             full_o,
   output logic [NUM_CHAN-1:0][WORD_W-1:0]  frame_o
);
   localparam int unsigned IDX_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHAN - 1);

   logic [IDX_W-1:0] idx_q;
   logic             full_q;
   logic             accept;

   assign in_ready = !full_q;
   assign accept   = in_valid && !full_q;
   assign full_o   = full_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q  <= '0;
         full_q <= 1'b0;
      end else if (accept) begin
         if (idx_q == LAST_IDX) begin
            idx_q  <= '0;
            full_q <= 1'b1;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end else if (release_i) begin
         full_q <= 1'b0;
      end
   end

   for (genvar b = 0; b < NUM_CHAN; b++) begin : g_slot
      logic [WORD_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (rst)
            slot_q <= '0;
         else if (accept && idx_q == IDX_W'(b))
            slot_q <= in_data;
      end
      assign frame_o[b] = slot_q;
   end
endmodule

// File: rtl/seq_compare.sv
module seq_compare
   import aligner_pkg::*;
(
   input  cword_t a_seq,
   input  cword_t b_seq,
   output logic   equal_o,
   output logic   a_lags_o
);
   assign equal_o  = (a_seq == b_seq);
   assign a_lags_o = seq_lags(a_seq, b_seq);
endmodule

// File: rtl/lockstep_emitter.sv
module lockstep_emitter #(
   parameter int unsigned NUM_CHAN = 2,
   parameter int unsigned WORD_W   = 32
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             match_i,
   input  logic [NUM_CHAN-1:0][WORD_W-1:0]  frame_a,
   input  logic [NUM_CHAN-1:0][WORD_W-1:0]  frame_b,
   input  logic                             ready_a,
   input  logic                             ready_b,
   output logic                             valid_o,
   output logic [WORD_W-1:0]                data_a,
   output logic [WORD_W-1:0]                data_b,
   output logic                             last_fire_o
);
   localparam int unsigned IDX_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHAN - 1);

   logic [IDX_W-1:0] beat_q;

   assign valid_o     = match_i && ready_a && ready_b;
   assign last_fire_o = valid_o && (beat_q == LAST_IDX);
   assign data_a      = frame_a[beat_q];
   assign data_b      = frame_b[beat_q];

   always_ff @(posedge clk) begin
      if (rst)
         beat_q <= '0;
      else if (valid_o)
         beat_q <= (beat_q == LAST_IDX) ? '0 : beat_q + 1'b1;
   end
endmodule

// File: rtl/seqnum_stream_aligner.sv
module seqnum_stream_aligner
   import aligner_pkg::*;
#(
   parameter int unsigned NUM_CHAN       = 2,
   parameter int unsigned ALIGN_INTERVAL = 0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        m_in_valid,
   output logic        m_in_ready,
   input  logic [31:0] m_in_data,
   input  logic        s_in_valid,
   output logic        s_in_ready,
   input  logic [31:0] s_in_data,
   output logic        m_out_valid,
   input  logic        m_out_ready,
   output logic [31:0] m_out_data,
   output logic        s_out_valid,
   input  logic        s_out_ready,
   output logic [31:0] s_out_data,
   output logic        align_lost
);
   localparam int unsigned WORD_W = CWORD_W;

   if (NUM_CHAN != 2 && NUM_CHAN != 4) begin : g_bad_chan
      $error("seqnum_stream_aligner: NUM_CHAN must be 2 or 4");
   end
   if (ALIGN_INTERVAL > 32'h7FFF_FFFF) begin : g_bad_interval
      $error("seqnum_stream_aligner: ALIGN_INTERVAL out of range");
   end

   logic                            full_m, full_s;
   logic                            rel_m, rel_s;
   logic [NUM_CHAN-1:0][WORD_W-1:0] frame_m, frame_s;
   logic                            seq_eq, m_lags;
   logic                            both_full, match, mismatch;
   logic                            out_valid, last_fire;
   logic                            aligned_q, lost_q;

   frame_collector #(.NUM_CHAN(NUM_CHAN), .WORD_W(WORD_W)) u_col_m (
      .clk(clk), .rst(rst), .in_valid(m_in_valid), .in_ready(m_in_ready),
      .in_data(m_in_data), .release_i(rel_m), .full_o(full_m), .frame_o(frame_m));

   frame_collector #(.NUM_CHAN(NUM_CHAN), .WORD_W(WORD_W)) u_col_s (
      .clk(clk), .rst(rst), .in_valid(s_in_valid), .in_ready(s_in_ready),
      .in_data(s_in_data), .release_i(rel_s), .full_o(full_s), .frame_o(frame_s));

   seq_compare u_cmp (
      .a_seq(frame_m[0]), .b_seq(frame_s[0]), .equal_o(seq_eq), .a_lags_o(m_lags));

   assign both_full = full_m && full_s;
   assign match     = both_full && seq_eq;
   assign mismatch  = both_full && !seq_eq;

   lockstep_emitter #(.NUM_CHAN(NUM_CHAN), .WORD_W(WORD_W)) u_emit (
      .clk(clk), .rst(rst), .match_i(match), .frame_a(frame_m), .frame_b(frame_s),
      .ready_a(m_out_ready), .ready_b(s_out_ready), .valid_o(out_valid),
      .data_a(m_out_data), .data_b(s_out_data), .last_fire_o(last_fire));

   always_comb begin
      rel_m = last_fire || (mismatch && m_lags);
      rel_s = last_fire || (mismatch && !m_lags);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         aligned_q <= 1'b0;
         lost_q    <= 1'b0;
      end else if (mismatch) begin
         aligned_q <= 1'b0;
         if (aligned_q) lost_q <= 1'b1;
      end else if (last_fire) begin
         aligned_q <= 1'b1;
      end
   end

   assign m_out_valid = out_valid;
   assign s_out_valid = out_valid;
   assign align_lost  = lost_q;
endmodule

// File: rtl/aligner_checks.sv
module aligner_checks #(
   parameter int unsigned NUM_CHAN = 2
) (
   input logic        clk,
   input logic        rst,
   input logic        m_out_valid,
   input logic        m_out_ready,
   input logic [31:0] m_out_data,
   input logic        s_out_valid,
   input logic        s_out_ready,
   input logic [31:0] s_out_data,
   input logic        align_lost
);
   logic [2:0] ck_beat;

   always_ff @(posedge clk) begin
      if (rst)
         ck_beat <= '0;
      else if (m_out_valid)
         ck_beat <= (ck_beat == 3'(NUM_CHAN - 1)) ? '0 : ck_beat + 1'b1;
   end

   assert_valid_pair_R6: assert property (@(posedge clk) disable iff (rst)
      m_out_valid == s_out_valid);

   assert_valid_needs_ready_R6: assert property (@(posedge clk) disable iff (rst)
      m_out_valid |-> (m_out_ready && s_out_ready));

   assert_head_seq_equal_R3: assert property (@(posedge clk) disable iff (rst)
      (m_out_valid && ck_beat == 3'd0) |-> (m_out_data == s_out_data));

   assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      align_lost |=> align_lost);
endmodule

bind seqnum_stream_aligner aligner_checks #(.NUM_CHAN(NUM_CHAN)) u_checks (
   .clk(clk), .rst(rst),
   .m_out_valid(m_out_valid), .m_out_ready(m_out_ready), .m_out_data(m_out_data),
   .s_out_valid(s_out_valid), .s_out_ready(s_out_ready), .s_out_data(s_out_data),
   .align_lost(align_lost));

// File: tb/tb_seqnum_stream_aligner.sv
`timescale 1ns/1ps
module tb_seqnum_stream_aligner;
   localparam int NCH = 4;
   localparam logic [7:0] TAG_M = 8'hA1;
   localparam logic [7:0] TAG_S = 8'h5B;

   logic clk = 1'b0;
   logic rst;
   logic m_in_valid, s_in_valid, m_in_ready, s_in_ready;
   logic [31:0] m_in_data, s_in_data, m_out_data, s_out_data;
   logic m_out_valid, s_out_valid, m_out_ready, s_out_ready, align_lost;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [31:0] cap_m [0:63];
   logic [31:0] cap_s [0:63];
   int ncap = 0;

   always #4 clk = ~clk;

   seqnum_stream_aligner #(.NUM_CHAN(NCH), .ALIGN_INTERVAL(16)) dut (
      .clk(clk), .rst(rst),
      .m_in_valid(m_in_valid), .m_in_ready(m_in_ready), .m_in_data(m_in_data),
      .s_in_valid(s_in_valid), .s_in_ready(s_in_ready), .s_in_data(s_in_data),
      .m_out_valid(m_out_valid), .m_out_ready(m_out_ready), .m_out_data(m_out_data),
      .s_out_valid(s_out_valid), .s_out_ready(s_out_ready), .s_out_data(s_out_data),
      .align_lost(align_lost));

   always @(negedge clk) begin
      if (!rst && m_out_valid && ncap < 64) begin
         cap_m[ncap] = m_out_data;
         cap_s[ncap] = s_out_data;
         ncap = ncap + 1;
      end
   end

   function automatic logic [31:0] word_of(input logic [31:0] seq, input logic [7:0] tag, input int k);
      return (k == 0) ? seq : {tag, seq[15:0], 8'(k)};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic send_m(input logic [31:0] seq, input int first, input int last);
      for (int k = first; k <= last; k++) begin
         int w = 0;
         @(posedge clk); #1;
         while (!m_in_ready && w < 300) begin @(posedge clk); #1; w++; end
         if (w >= 300) begin check(1'b0, "R9 master input stuck", 32'(m_in_ready), 32'd1); return; end
         m_in_valid = 1'b1; m_in_data = word_of(seq, TAG_M, k);
         @(posedge clk); #1;
         m_in_valid = 1'b0;
      end
   endtask

   task automatic send_s(input logic [31:0] seq, input int first, input int last);
      for (int k = first; k <= last; k++) begin
         int w = 0;
         @(posedge clk); #1;
         while (!s_in_ready && w < 300) begin @(posedge clk); #1; w++; end
         if (w >= 300) begin check(1'b0, "R9 slave input stuck", 32'(s_in_ready), 32'd1); return; end
         s_in_valid = 1'b1; s_in_data = word_of(seq, TAG_S, k);
         @(posedge clk); #1;
         s_in_valid = 1'b0;
      end
   endtask

   task automatic settle();
      repeat (30) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      m_in_valid = 1'b0; s_in_valid = 1'b0;
      m_in_data = '0; s_in_data = '0;
      m_out_ready = 1'b1; s_out_ready = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      ncap = 0;
   endtask

   task automatic check_frame(input int base, input logic [31:0] seq, input string req);
      for (int k = 0; k < NCH; k++) begin
         check(cap_m[base+k] == word_of(seq, TAG_M, k), req, cap_m[base+k], word_of(seq, TAG_M, k));
         check(cap_s[base+k] == word_of(seq, TAG_S, k), req, cap_s[base+k], word_of(seq, TAG_S, k));
      end
   endtask

   // R1
   task automatic t_reset();
      rst = 1'b1;
      m_in_valid = 1'b0; s_in_valid = 1'b0;
      m_out_ready = 1'b1; s_out_ready = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check(!m_out_valid && !s_out_valid, "R1 out valid in reset", {m_out_valid, s_out_valid}, 0);
      check(m_in_ready && s_in_ready, "R1 in ready in reset", {m_in_ready, s_in_ready}, 3);
      check(!align_lost, "R1 lost flag in reset", 32'(align_lost), 0);
      rst = 1'b0;
      @(posedge clk); #1;
      check(!m_out_valid && m_in_ready && s_in_ready && !align_lost, "R1 after release",
            {m_out_valid, m_in_ready, s_in_ready, align_lost}, 32'b0110);
   endtask

   // R2 R3: equal sequence numbers, including a value with distinct I and Q halves
   task automatic t_equal();
      do_reset();
      fork send_m(32'h1234_0064, 0, NCH-1); send_s(32'h1234_0064, 0, NCH-1); join
      settle();
      check(ncap == NCH, "R3 one frame emitted", ncap, NCH);
      check_frame(0, 32'h1234_0064, "R2 R3 frame content");
      check(cap_m[0][31:16] == 16'h1234, "R2 I half is upper", cap_m[0][31:16], 32'h1234);
   endtask

   // R4: master lags, then slave lags
   task automatic t_master_lags();
      do_reset();
      fork
         begin send_m(5, 0, NCH-1); send_m(6, 0, NCH-1); send_m(7, 0, NCH-1); end
         send_s(7, 0, NCH-1);
      join
      settle();
      check(ncap == NCH, "R4 master lag drops", ncap, NCH);
      check_frame(0, 7, "R4 master lag frame");
      check(!align_lost, "R8 drops before alignment", 32'(align_lost), 0);
   endtask

   task automatic t_slave_lags();
      do_reset();
      fork
         send_m(22, 0, NCH-1);
         begin send_s(20, 0, NCH-1); send_s(21, 0, NCH-1); send_s(22, 0, NCH-1); end
      join
      settle();
      check(ncap == NCH, "R4 slave lag drops", ncap, NCH);
      check_frame(0, 22, "R4 slave lag frame");
   endtask

   // R5
   task automatic t_wrap();
      do_reset();
      fork
         begin send_m(32'hFFFF_FFFE, 0, NCH-1); send_m(32'hFFFF_FFFF, 0, NCH-1); send_m(0, 0, NCH-1); end
         send_s(0, 0, NCH-1);
      join
      settle();
      check(ncap == NCH, "R5 wrap frame count", ncap, NCH);
      check_frame(0, 0, "R5 wrap frame");
   endtask

   // R6 R9
   task automatic t_backpressure();
      do_reset();
      s_out_ready = 1'b0;
      fork send_m(50, 0, NCH-1); send_s(50, 0, NCH-1); join
      settle();
      check(ncap == 0, "R6 no output while one sink stalls", ncap, 0);
      check(!m_out_valid, "R6 master valid held low", 32'(m_out_valid), 0);
      check(!m_in_ready && !s_in_ready, "R9 inputs blocked while held", {m_in_ready, s_in_ready}, 0);
      s_out_ready = 1'b1;
      settle();
      check(ncap == NCH, "R6 emission after release", ncap, NCH);
      check_frame(0, 50, "R6 frame after stall");
   endtask

   // R7
   task automatic t_partial();
      do_reset();
      fork send_m(40, 0, NCH-1); send_s(40, 0, 1); join
      settle();
      check(ncap == 0, "R7 partial frame not emitted", ncap, 0);
      check(!m_in_ready, "R9 master held frame blocks", 32'(m_in_ready), 0);
      check(s_in_ready, "R7 slave still takes words", 32'(s_in_ready), 1);
      send_s(40, 2, NCH-1);
      settle();
      check(ncap == NCH, "R7 frame after completion", ncap, NCH);
      check_frame(0, 40, "R7 completed frame");
   endtask

   // R8
   task automatic t_lost();
      do_reset();
      fork send_m(10, 0, NCH-1); send_s(10, 0, NCH-1); join
      settle();
      check(!align_lost, "R8 low after first match", 32'(align_lost), 0);
      fork
         begin send_m(11, 0, NCH-1); send_m(12, 0, NCH-1); end
         send_s(12, 0, NCH-1);
      join
      settle();
      check(align_lost, "R8 set after mismatch", 32'(align_lost), 1);
      check(ncap == 2*NCH, "R8 realigned frame count", ncap, 2*NCH);
      check_frame(NCH, 12, "R8 realigned frame");
      fork send_m(13, 0, NCH-1); send_s(13, 0, NCH-1); join
      settle();
      check(align_lost, "R8 stays set", 32'(align_lost), 1);
      do_reset();
      check(!align_lost, "R8 reset clears", 32'(align_lost), 0);
   endtask

   initial begin
      t_reset();
      t_equal();
      t_master_lags();
      t_slave_lags();
      t_wrap();
      t_backpressure();
      t_partial();
      t_lost();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule